// File: doc/BRIEF.md
# Calibration Pulse Generator with Power Direction Flag

This block turns a stream of signed, already filtered real-power samples into a fast pulse train. The pulse rate is proportional to instantaneous real power and is meant for meter calibration. The magnitude of each accepted sample is added into an energy accumulator. A pulse is issued each time the accumulator reaches a threshold, and the excess above the threshold is kept for the next interval. The threshold sets the rate. It is a power-of-two fraction of the threshold used by the slow pulse outputs, so the fast train runs at a select-dependent multiple of the slow rate, from 16x up to 2048x.

The pulse width follows a rule that depends on the mode:
- In the ordinary modes a pulse lasts a nominal number of cycles.
- When pulses arrive faster than twice that width, a pulse lasts half of the interval that has just ended.
- The 2048x mode always uses a short fixed width.

A no-load qualifier stops accumulation in every mode except 2048x. A direction flag reports negative power. It is not latched, and it is updated only at the instant a pulse is issued, from the sign of the signed energy summed over the interval that this pulse closes.

Top module: `calpulse_gen`

## Requirements
- R1: The select `cal_sel` picks a rate shift k, and the pulse threshold is 2^(BASE_LOG2-k). The encodings are 3'b100 k=7, 3'b000 k=6, 3'b101 k=6, 3'b001 k=5, 3'b110 k=5, 3'b010 k=4, 3'b111 k=4 and 3'b011 k=11 (fast mode). A pulse is issued only when the accumulated sample magnitude reaches the threshold.
- R2: When a pulse is issued, the threshold is subtracted from the accumulator and the remainder counts toward the next pulse.
- R3: In the ordinary modes, if the interval ending at a pulse is at least 2*PW_NOM cycles, the pulse is high for PW_NOM cycles. The interval is measured from the previous pulse, or from reset for the first pulse.
- R4: In the ordinary modes, if that interval is shorter than 2*PW_NOM cycles, the pulse is high for half the interval, rounded down, with a minimum of 1 cycle.
- R5: In fast mode (`cal_sel`=3'b011) every pulse is high for PW_FAST cycles, whatever the rate.
- R6: While `no_load` is high, samples are ignored and no pulse is issued, except in fast mode, where `no_load` has no effect.
- R7: At each pulse, `neg_flag` is set to 1 if the signed sum of the samples accepted during the interval closed by that pulse is negative, and to 0 otherwise. The flag returns to 0 once an interval with positive sum ends.
- R8: `neg_flag` changes only on the clock edge at which a pulse is issued.
- R9: Reset (`rst_n` low) clears the accumulator and the interval count, drives `cal_pulse` low and clears `neg_flag`.
- R10: `cal_pulse` goes high on the same clock edge that accepts the sample completing the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_sel | input | 3 | Rate select, encoded as listed in R1 |
| pwr_sample | input | SAMPLE_W | Signed real-power sample |
| pwr_valid | input | 1 | Sample strobe; the sample is used on cycles where this is high |
| no_load | input | 1 | No-load qualifier; blocks accumulation outside fast mode |
| cal_pulse | output | 1 | Active-high calibration pulse |
| neg_flag | output | 1 | Negative-power flag, updated only at a pulse |

## Verification
The assertions check four things on every cycle:
- the direction flag never changes except on a pulse issue;
- every issue raises the pulse, and every rising edge of the pulse comes from an issue;
- no issue occurs while the no-load gate is active;
- both outputs come out of reset low.

Three things can only be shown by the bench's scenarios, because each needs a known load over many cycles:
- the threshold chosen for each select code;
- the width rule in its three forms (nominal, half-interval and fast fixed);
- the remainder that carries from one interval to the next.

// File: rtl/calpulse_pkg.sv
package calpulse_pkg;

    typedef struct packed {
        logic [3:0] shift;
        logic       fast;
    } rate_t;

    function automatic rate_t decode_rate(input logic [2:0] sel);
        rate_t r;
        r.fast = 1'b0;
        case (sel)
            3'b100:  r.shift = 4'd7;
            3'b000:  r.shift = 4'd6;
            3'b101:  r.shift = 4'd6;
            3'b001:  r.shift = 4'd5;
            3'b110:  r.shift = 4'd5;
            3'b010:  r.shift = 4'd4;
            3'b111:  r.shift = 4'd4;
            default: begin
                r.shift = 4'd11;
                r.fast  = 1'b1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/calpulse_rate_decode.sv
module calpulse_rate_decode
    import calpulse_pkg::*;
#(
    parameter int BASE_LOG2 = 20,
    localparam int THR_W    = BASE_LOG2 + 1
) (
    input  logic [2:0]       sel,
    output logic [THR_W-1:0] thr,
    output logic             fast
);
    rate_t      rate;
    logic [5:0] sh_amt;

    always_comb begin
        rate   = decode_rate(sel);
        sh_amt = 6'(BASE_LOG2) - 6'(rate.shift);
        thr    = THR_W'(1) << sh_amt;
        fast   = rate.fast;
    end
endmodule

// File: rtl/calpulse_energy_acc.sv
module calpulse_energy_acc #(
    parameter int SAMPLE_W = 16,
    parameter int THR_W    = 21,
    parameter int ACC_W    = 22
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic                       valid,
    input  logic                       suppress,
    input  logic [THR_W-1:0]           thr,
    output logic                       issue_o,
    output logic                       neg_next_o
);
    typedef struct packed {
        logic [ACC_W-1:0] mag_acc;
        logic [ACC_W-1:0] sgn_acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W-1:0] s_ext;
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] mag_sum;
    logic [ACC_W-1:0] sgn_sum;
    logic             take;

    always_comb begin
        s_ext      = {{(ACC_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
        mag        = s_ext[ACC_W-1] ? (~s_ext + ACC_W'(1)) : s_ext;
        take       = valid && !suppress;
        mag_sum    = st_q.mag_acc + mag;
        sgn_sum    = st_q.sgn_acc + s_ext;
        issue_o    = take && (mag_sum >= ACC_W'(thr));
        neg_next_o = sgn_sum[ACC_W-1];
        st_d       = st_q;
        if (take) begin
            if (issue_o) begin
                st_d.mag_acc = mag_sum - ACC_W'(thr);
                st_d.sgn_acc = '0;
            end else begin
                st_d.mag_acc = mag_sum;
                st_d.sgn_acc = sgn_sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/calpulse_shaper.sv
module calpulse_shaper #(
    parameter int PW_NOM  = 90,
    parameter int PW_FAST = 18,
    localparam int CAP    = 2 * PW_NOM,
    localparam int CNT_W  = $clog2(CAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic fast,
    input  logic neg_next,
    output logic pulse_o,
    output logic neg_o
);
    typedef struct packed {
        logic             pulse;
        logic             neg;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] period;
    } shp_state_t;

    shp_state_t st_d, st_q;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] width;

    always_comb begin
        per = (st_q.period == CNT_W'(CAP)) ? CNT_W'(CAP) : st_q.period + CNT_W'(1);
        if (fast)
            width = CNT_W'(PW_FAST);
        else if (per >= CNT_W'(CAP))
            width = CNT_W'(PW_NOM);
        else
            width = per >> 1;
        if (width == '0)
            width = CNT_W'(1);

        st_d = st_q;
        if (issue) begin
            st_d.pulse  = 1'b1;
            st_d.hold   = width - CNT_W'(1);
            st_d.period = '0;
            st_d.neg    = neg_next;
        end else begin
            st_d.period = per;
            if (st_q.hold != '0)
                st_d.hold = st_q.hold - CNT_W'(1);
            else
                st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign neg_o   = st_q.neg;
endmodule

// File: rtl/calpulse_gen.sv
module calpulse_gen #(
    parameter int SAMPLE_W  = 16,
    parameter int BASE_LOG2 = 20,
    parameter int PW_NOM    = 90,
    parameter int PW_FAST   = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 cal_sel,
    input  logic signed [SAMPLE_W-1:0] pwr_sample,
    input  logic                       pwr_valid,
    input  logic                       no_load,
    output logic                       cal_pulse,
    output logic                       neg_flag
);
    localparam int THR_W = BASE_LOG2 + 1;
    localparam int ACC_W = ((BASE_LOG2 > SAMPLE_W) ? BASE_LOG2 : SAMPLE_W) + 2;

    logic [THR_W-1:0] thr;
    logic             fast;
    logic             suppress;
    logic             issue;
    logic             neg_next;

    calpulse_rate_decode #(.BASE_LOG2(BASE_LOG2)) u_rate (
        .sel  (cal_sel),
        .thr  (thr),
        .fast (fast)
    );

    // creep gate: the no-load qualifier only acts outside fast mode (R6)
    assign suppress = no_load && !fast;

    calpulse_energy_acc #(
        .SAMPLE_W (SAMPLE_W),
        .THR_W    (THR_W),
        .ACC_W    (ACC_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (pwr_sample),
        .valid      (pwr_valid),
        .suppress   (suppress),
        .thr        (thr),
        .issue_o    (issue),
        .neg_next_o (neg_next)
    );

    calpulse_shaper #(
        .PW_NOM  (PW_NOM),
        .PW_FAST (PW_FAST)
    ) u_shp (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .fast     (fast),
        .neg_next (neg_next),
        .pulse_o  (cal_pulse),
        .neg_o    (neg_flag)
    );
endmodule

// File: rtl/calpulse_gen_chk.sv
module calpulse_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic cal_pulse,
    input logic neg_flag,
    input logic issue,
    input logic suppress
);
    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cal_pulse && !neg_flag));

    // R10
    issue_sets_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> cal_pulse);

    // R10
    rise_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_pulse) |-> $past(issue));

    // R8
    dir_only_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(neg_flag) |-> $past(issue));

    // R6
    creep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |-> !issue);
endmodule

bind calpulse_gen calpulse_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_pulse (cal_pulse),
    .neg_flag  (neg_flag),
    .issue     (issue),
    .suppress  (suppress)
);

// File: tb/calpulse_gen_tb.sv
module calpulse_gen_tb;
    localparam int BASE_LOG2 = 20;
    localparam int PW_NOM    = 90;
    localparam int PW_FAST   = 18;

    typedef struct packed {
        logic [2:0]          sel;
        logic                nl;
        logic signed [15:0]  s;
        logic [31:0]         n;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 1'b0,  16'sd1024, 32'd200},
        '{3'b100, 1'b0, -16'sd512,  32'd200},
        '{3'b010, 1'b0,  16'sd4096, 32'd200},
        '{3'b011, 1'b0,  16'sd16,   32'd400},
        '{3'b011, 1'b1,  16'sd16,   32'd400},
        '{3'b001, 1'b1,  16'sd2048, 32'd200},
        '{3'b110, 1'b0, -16'sd2048, 32'd200},
        '{3'b101, 1'b0,  16'sd1024, 32'd200},
        '{3'b111, 1'b0, -16'sd4096, 32'd200},
        '{3'b000, 1'b0,  16'sd64,   32'd600},
        '{3'b100, 1'b0,  16'sd64,   32'd600}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cal_sel = 3'b000;
    logic signed [15:0] pwr_sample = '0;
    logic              pwr_valid = 1'b0;
    logic              no_load = 1'b0;
    logic              cal_pulse;
    logic              neg_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    calpulse_gen #(
        .SAMPLE_W  (16),
        .BASE_LOG2 (BASE_LOG2),
        .PW_NOM    (PW_NOM),
        .PW_FAST   (PW_FAST)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_sel    (cal_sel),
        .pwr_sample (pwr_sample),
        .pwr_valid  (pwr_valid),
        .no_load    (no_load),
        .cal_pulse  (cal_pulse),
        .neg_flag   (neg_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int shift_of(input logic [2:0] sel);
        case (sel)
            3'b100: return 7;
            3'b000, 3'b101: return 6;
            3'b001, 3'b110: return 5;
            3'b010, 3'b111: return 4;
            default: return 11;
        endcase
    endfunction

    task automatic do_reset;
        rst_n     = 1'b0;
        pwr_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input bit v, input int s);
        pwr_valid  = v;
        pwr_sample = 16'(s);
        @(negedge clk);
    endtask

    // feed samples spaced by gap cycles, counting rising edges of the pulse
    task automatic feed(input int count, input int s, input int gap, output int rises);
        bit prev = cal_pulse;
        rises = 0;
        for (int i = 0; i < count * gap; i++) begin
            step((i % gap) == 0, s);
            if (cal_pulse && !prev) rises++;
            prev = cal_pulse;
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int  mag, thr, exp_r, per, exp_w, rises, run, lastw;
        bit  fast, prev, exp_neg;
        cal_sel = v.sel;
        no_load = v.nl;
        do_reset();
        prev = 1'b0; rises = 0; run = 0; lastw = 0;
        for (int i = 0; i < int'(v.n) + 300; i++) begin
            step(i < int'(v.n), int'(v.s));
            if (cal_pulse && !prev) begin
                rises++;
                run = 1;
            end else if (cal_pulse) begin
                run++;
            end else if (prev) begin
                lastw = run;
            end
            prev = cal_pulse;
        end
        mag   = (v.s < 0) ? -int'(v.s) : int'(v.s);
        thr   = 1 << (BASE_LOG2 - shift_of(v.sel));
        fast  = (v.sel == 3'b011);
        exp_r = (v.nl && !fast) ? 0 : (int'(v.n) * mag) / thr;
        per   = thr / mag;
        exp_w = fast ? PW_FAST : ((per >= 2 * PW_NOM) ? PW_NOM : per / 2);
        exp_neg = (exp_r > 0) && (v.s < 0);
        // R1 rate per select, R6 no-load gating
        chk(v.nl ? "R6" : "R1", $sformatf("vector %0d pulse count", idx), rises, exp_r);
        if (exp_r > 0)
            chk(fast ? "R5" : ((per >= 2 * PW_NOM) ? "R3" : "R4"),
                $sformatf("vector %0d pulse width", idx), lastw, exp_w);
        chk("R7", $sformatf("vector %0d direction", idx), int'(neg_flag), int'(exp_neg));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int r;
        // R9 reset state
        do_reset();
        chk("R9", "pulse after reset", int'(cal_pulse), 0);
        chk("R9", "flag after reset", int'(neg_flag), 0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // R1 / R10 exact threshold timing and R7 / R8 direction timing
        cal_sel = 3'b000;
        no_load = 1'b0;
        do_reset();
        for (int i = 0; i < 15; i++) step(1'b1, 1024);
        chk("R1", "no pulse one sample short of threshold", int'(cal_pulse), 0);
        step(1'b1, 1024);
        chk("R10", "pulse on threshold edge", int'(cal_pulse), 1);
        chk("R7", "flag after positive interval", int'(neg_flag), 0);
        for (int i = 0; i < 8; i++) step(1'b1, -1024);
        chk("R8", "flag held between pulses", int'(neg_flag), 0);
        for (int i = 0; i < 8; i++) step(1'b1, -1024);
        chk("R10", "pulse after negative interval", int'(cal_pulse), 1);
        chk("R7", "flag after negative interval", int'(neg_flag), 1);
        for (int i = 0; i < 16; i++) step(1'b1, 1024);
        chk("R7", "flag cleared by positive interval", int'(neg_flag), 0);

        // R2 remainder carried, then R9 clears the accumulator
        do_reset();
        feed(3, -10000, 8, r);
        chk("R2", "pulses after three samples", r, 1);
        feed(1, -10000, 8, r);
        chk("R2", "pulse from carried remainder", r, 1);
        chk("R7", "flag for negative load", int'(neg_flag), 1);
        do_reset();
        chk("R9", "flag cleared by reset", int'(neg_flag), 0);
        chk("R9", "pulse cleared by reset", int'(cal_pulse), 0);
        feed(1, -10000, 20, r);
        chk("R9", "no pulse from stale remainder", r, 0);

        finish_run();
    end
endmodule